// File: doc/BRIEF.md
# Disk Data Formatter Sequencer

This block moves sector data between a handshaked sector buffer port and an 8-bit byte bus to a read/write channel. The channel bus runs at a fixed byte rate. Each byte slot is marked by a one-cycle byte enable, and the channel never waits. On a write, the block prefetches user bytes from the buffer into a small FIFO. In every free slot it drives the next formatted byte: first the user bytes of the sector, then the check bytes supplied by an external error-correction unit. On a read, it captures the formatted bytes, sends the user bytes into the buffer, and presents the check bytes on a separate checker port.

Servo wedges interrupt the track. While the wedge input is high, the write gate is dropped, no byte is driven and no byte is captured. The sector field in progress simply resumes in the first free slot after the wedge, so a sector can be split around any number of wedges. A wedge that falls exactly between two sectors only delays the start of the next sector.

A transfer starts with a start pulse. The pulse carries the direction and the sector count. The transfer ends with a single done pulse, or it ends early on a write underrun. Two sticky error flags report a write underrun and a read overrun.

Top module: `disk_fmt_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wr_gate`, `nrz_out_vld`, `chk_req`, `chk_out_valid`, `buf_wr_valid`, `err_underrun` and `err_overrun` are all 0.
- R2: On a write, every sector appears on `nrz_out` as its user bytes in buffer order, followed by its check bytes. A check byte is the value on `chk_data` in the cycle where `chk_req` is 1. Exactly one byte is driven per slot: a slot is a cycle with `byte_en`=1 and `wedge`=0, and `nrz_out_vld` is 1 in that same cycle.
- R3: While `wedge`=1, `wr_gate`=0 and `nrz_out_vld`=0, and no read byte is captured. The field in progress continues unchanged in the next slot after the wedge.
- R4: On a read, the user bytes of every sector leave on the buffer write port in capture order. The check bytes are never sent to the buffer. Each check byte appears on `chk_out_data`, with `chk_out_valid`=1, in the cycle after its slot.
- R5: A value of 0 on `cfg_user_len` selects 512 user bytes per sector, and a value of 0 on `cfg_chk_len` selects 4 check bytes. Both values are sampled at start.
- R6: On a write, a user-byte slot that finds the FIFO empty sets the sticky `err_underrun`. In that case `wr_gate` falls and the transfer ends without `done`. The next accepted start clears `err_underrun`.
- R7: On a read, a user byte that arrives while the 8-entry FIFO is full is dropped and sets the sticky `err_overrun`. The transfer still runs to completion and raises `done`.
- R8: `done` is a one-cycle pulse and `busy` falls with it. On a write, `done` comes in the cycle after the last check byte. On a read, it comes once the last check byte has been captured and the FIFO has drained.
- R9: A start is ignored while `busy`=1, and a start with `start_secs`=0 is ignored.
- R10: `buf_rd_ready` is 1 only during a write, only while the FIFO is not full, and only while fewer than user-length × sector-count bytes have been fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_user_len | input | LEN_W | User bytes per sector (0 = 512) |
| cfg_chk_len | input | CHK_W | Check bytes per sector (0 = 4) |
| start | input | 1 | Start pulse |
| start_write | input | 1 | 1 = write transfer, 0 = read transfer |
| start_secs | input | SEC_W | Sector count for the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_rd_valid | input | 1 | Buffer offers a user byte |
| buf_rd_data | input | 8 | User byte from the buffer |
| buf_rd_ready | output | 1 | Block accepts the offered byte |
| buf_wr_valid | output | 1 | Block offers a recovered user byte |
| buf_wr_data | output | 8 | Recovered user byte |
| buf_wr_ready | input | 1 | Buffer accepts the byte |
| chk_req | output | 1 | Check byte consumed this cycle (write) |
| chk_data | input | 8 | Check byte from the error-correction unit |
| chk_out_valid | output | 1 | Captured check byte valid (read) |
| chk_out_data | output | 8 | Captured check byte |
| byte_en | input | 1 | Channel byte slot strobe |
| wedge | input | 1 | Servo wedge gate |
| nrz_in | input | 8 | Byte from the channel |
| nrz_out | output | 8 | Byte to the channel |
| nrz_out_vld | output | 1 | `nrz_out` carries a byte this cycle |
| wr_gate | output | 1 | Write gate to the channel |
| err_underrun | output | 1 | Sticky write underrun |
| err_overrun | output | 1 | Sticky read overrun |

## Verification
Two of this block's functions can fall in the same cycle on one FIFO. On a write, a buffer fetch and a channel slot can both use the FIFO in the same cycle. On a read, a captured byte and a drain to the buffer can likewise coincide, and a wedge can also begin on the very slot of a sector boundary. The bench provokes these overlaps with a fixed-rate slot strobe, wedge windows of random placement and length, and random stalls on the buffer sink. A scoreboard judges every emitted byte against the queued user-then-check order, so a lost, repeated or swapped byte in any such cycle shows up as a mismatch.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_DRAIN = 2'd3
   } fmt_state_t;
endpackage

// File: rtl/fmt_fifo.sv
module fmt_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fmt_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [AW:0]   cnt;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R6
endmodule

// File: rtl/fmt_frame_ctr.sv
module fmt_frame_ctr #(
   parameter int LEN_W = 12,
   parameter int CHK_W = 6,
   parameter int SEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] ulen,
   input  logic [CHK_W-1:0] clen,
   input  logic [SEC_W-1:0] secs,
   input  logic             step,
   output logic             in_chk,
   output logic             last_slot
);
   logic [LEN_W-1:0] ulen_q, upos;
   logic [CHK_W-1:0] clen_q, kpos;
   logic [SEC_W-1:0] sleft;
   logic             user_end, chk_end;

   assign user_end  = (upos == ulen_q - LEN_W'(1));
   assign chk_end   = (kpos == clen_q - CHK_W'(1));
   assign last_slot = in_chk && chk_end && (sleft == SEC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ulen_q <= '0;
         clen_q <= '0;
         upos   <= '0;
         kpos   <= '0;
         sleft  <= '0;
         in_chk <= 1'b0;
      end else if (load) begin
         ulen_q <= ulen;
         clen_q <= clen;
         sleft  <= secs;
         upos   <= '0;
         kpos   <= '0;
         in_chk <= 1'b0;
      end else if (step) begin
         if (!in_chk) begin
            if (user_end) begin
               upos   <= '0;
               in_chk <= 1'b1;
            end else begin
               upos <= upos + 1'b1;
            end
         end else begin
            if (chk_end) begin
               kpos   <= '0;
               in_chk <= 1'b0;
               sleft  <= sleft - SEC_W'(1);
            end else begin
               kpos <= kpos + 1'b1;
            end
         end
      end
   end

   AST_SLOT_WITHIN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (sleft != '0));  // R8
endmodule

// File: rtl/fmt_fetch.sv
module fmt_fetch #(
   parameter int TOT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOT_W-1:0] total,
   input  logic             take,
   output logic             more
);
   logic [TOT_W-1:0] left;

   assign more = (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     left <= '0;
      else if (load)  left <= total;
      else if (take)  left <= left - TOT_W'(1);
   end

   AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n) take |-> more);  // R10
endmodule

// File: rtl/disk_fmt_seq.sv
module disk_fmt_seq
   import fmt_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int CHK_W      = 6,
   parameter int SEC_W      = 8,
   parameter int FIFO_DEPTH = 8,
   parameter int DEF_ULEN   = 512,
   parameter int DEF_CLEN   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_user_len,
   input  logic [CHK_W-1:0] cfg_chk_len,
   input  logic             start,
   input  logic             start_write,
   input  logic [SEC_W-1:0] start_secs,
   output logic             busy,
   output logic             done,
   input  logic             buf_rd_valid,
   input  logic [7:0]       buf_rd_data,
   output logic             buf_rd_ready,
   output logic             buf_wr_valid,
   output logic [7:0]       buf_wr_data,
   input  logic             buf_wr_ready,
   output logic             chk_req,
   input  logic [7:0]       chk_data,
   output logic             chk_out_valid,
   output logic [7:0]       chk_out_data,
   input  logic             byte_en,
   input  logic             wedge,
   input  logic [7:0]       nrz_in,
   output logic [7:0]       nrz_out,
   output logic             nrz_out_vld,
   output logic             wr_gate,
   output logic             err_underrun,
   output logic             err_overrun
);
   localparam int TOT_W = LEN_W + SEC_W;

   generate
      if (FIFO_DEPTH < 8) begin : g_bad_fifo
         $error("disk_fmt_seq: FIFO_DEPTH must be at least 8");
      end
      if (DEF_ULEN < 1 || DEF_ULEN >= (1 << LEN_W)) begin : g_bad_ulen
         $error("disk_fmt_seq: DEF_ULEN does not fit LEN_W");
      end
      if (DEF_CLEN < 1 || DEF_CLEN >= (1 << CHK_W)) begin : g_bad_clen
         $error("disk_fmt_seq: DEF_CLEN does not fit CHK_W");
      end
   endgenerate

   fmt_state_t       state;
   logic             start_ok;
   logic [LEN_W-1:0] ulen_eff;
   logic [CHK_W-1:0] clen_eff;
   logic             slot, step, starve, in_chk, last_slot;
   logic             wr_mode, rd_mode, wr_user_slot, rd_user;
   logic             f_push, f_pop, f_full, f_empty;
   logic [7:0]       f_din, f_dout;
   logic             fetch_more, fetch_take, ovf;

   assign ulen_eff = (cfg_user_len == '0) ? LEN_W'(DEF_ULEN) : cfg_user_len;
   assign clen_eff = (cfg_chk_len == '0)  ? CHK_W'(DEF_CLEN) : cfg_chk_len;
   assign start_ok = start && (state == ST_IDLE) && (start_secs != '0);

   assign wr_mode      = (state == ST_WRITE);
   assign rd_mode      = (state == ST_READ);
   assign slot         = byte_en && !wedge && (wr_mode || rd_mode);
   assign wr_user_slot = slot && wr_mode && !in_chk;
   assign starve       = wr_user_slot && f_empty;
   assign step         = slot && !starve;
   assign rd_user      = step && rd_mode && !in_chk;
   assign ovf          = rd_user && f_full;

   // write side: prefetch from buffer, emit on slot
   assign buf_rd_ready = wr_mode && fetch_more && !f_full;
   assign fetch_take   = buf_rd_valid && buf_rd_ready;
   assign nrz_out_vld  = step && wr_mode;
   assign chk_req      = nrz_out_vld && in_chk;
   assign nrz_out      = !nrz_out_vld ? 8'h00 : (in_chk ? chk_data : f_dout);
   assign wr_gate      = wr_mode && !wedge;

   // read side: capture on slot, drain to buffer
   assign buf_wr_valid = (rd_mode || state == ST_DRAIN) && !f_empty;
   assign buf_wr_data  = f_dout;

   assign f_din  = wr_mode ? buf_rd_data : nrz_in;
   assign f_push = wr_mode ? fetch_take : (rd_user && !f_full);
   assign f_pop  = wr_mode ? (wr_user_slot && !f_empty) : (buf_wr_valid && buf_wr_ready);

   assign busy = (state != ST_IDLE);

   fmt_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .push  (f_push),
      .din   (f_din),
      .pop   (f_pop),
      .dout  (f_dout),
      .full  (f_full),
      .empty (f_empty)
   );

   fmt_frame_ctr #(.LEN_W(LEN_W), .CHK_W(CHK_W), .SEC_W(SEC_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .ulen      (ulen_eff),
      .clen      (clen_eff),
      .secs      (start_secs),
      .step      (step),
      .in_chk    (in_chk),
      .last_slot (last_slot)
   );

   fmt_fetch #(.TOT_W(TOT_W)) u_fetch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_ok && start_write),
      .total (TOT_W'(ulen_eff) * TOT_W'(start_secs)),
      .take  (fetch_take),
      .more  (fetch_more)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         done          <= 1'b0;
         err_underrun  <= 1'b0;
         err_overrun   <= 1'b0;
         chk_out_valid <= 1'b0;
         chk_out_data  <= 8'h00;
      end else begin
         done          <= 1'b0;
         chk_out_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  state        <= start_write ? ST_WRITE : ST_READ;
                  err_underrun <= 1'b0;
                  err_overrun  <= 1'b0;
               end
            end
            ST_WRITE: begin
               if (starve) begin
                  err_underrun <= 1'b1;
                  state        <= ST_IDLE;
               end else if (step && last_slot) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_READ: begin
               if (ovf) err_overrun <= 1'b1;
               if (step && in_chk) begin
                  chk_out_valid <= 1'b1;
                  chk_out_data  <= nrz_in;
               end
               if (step && last_slot) state <= ST_DRAIN;
            end
            ST_DRAIN: begin
               if (f_empty) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_NO_GATE_IN_WEDGE: assert property (@(posedge clk) disable iff (!rst_n)
      wedge |-> (!wr_gate && !nrz_out_vld));  // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R8
   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_underrun && !start_ok) |=> err_underrun);  // R6
   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun && !start_ok) |=> err_overrun);  // R7
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!nrz_out_vld && !buf_rd_ready && !chk_req && !buf_wr_valid));  // R10
   AST_CHK_NOT_TO_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      chk_out_valid |-> $past(!f_push));  // R4
endmodule

// File: tb/tb_disk_fmt_seq.sv
module tb_disk_fmt_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_user_len = '0;
   logic [5:0]  cfg_chk_len = '0;
   logic        start = 1'b0, start_write = 1'b0;
   logic [7:0]  start_secs = '0;
   logic        busy, done;
   logic        buf_rd_valid = 1'b0;
   logic [7:0]  buf_rd_data = '0;
   logic        buf_rd_ready, buf_wr_valid;
   logic [7:0]  buf_wr_data;
   logic        buf_wr_ready = 1'b0;
   logic        chk_req;
   logic [7:0]  chk_data = '0;
   logic        chk_out_valid;
   logic [7:0]  chk_out_data;
   logic        byte_en = 1'b0, wedge = 1'b0;
   logic [7:0]  nrz_in = '0;
   logic [7:0]  nrz_out;
   logic        nrz_out_vld, wr_gate, err_underrun, err_overrun;

   disk_fmt_seq dut (.*);

   always #2 clk = ~clk;

   logic [7:0] src_q[$], exp_wr_q[$], chk_src_q[$];
   logic [7:0] rd_stream_q[$], exp_buf_q[$], exp_chk_q[$];
   int checks = 0, fails = 0;
   int cyc = 0, be_div = 2, wedge_pct = 0, wedge_left = 0, stall_pct = 0;
   bit chan_on = 0, sink_hold = 0, rd_active = 0, cmp_buf = 1;
   int done_cnt = 0, wr_bytes = 0, buf_bytes = 0, wedge_viol = 0, idle_fetch = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // channel, buffer and check-unit models plus the monitor
   always @(negedge clk) begin
      cyc++;
      byte_en = chan_on && (cyc % be_div == 0);
      if (wedge_left > 0) begin
         wedge = 1'b1;
         wedge_left--;
      end else begin
         wedge = 1'b0;
         if (wedge_pct > 0 && $urandom_range(0, 99) < wedge_pct)
            wedge_left = $urandom_range(2, 9);
      end
      buf_rd_valid = (src_q.size() > 0);
      buf_rd_data  = buf_rd_valid ? src_q[0] : 8'h00;
      chk_data     = (chk_src_q.size() > 0) ? chk_src_q[0] : 8'h00;
      nrz_in       = (rd_stream_q.size() > 0) ? rd_stream_q[0] : 8'h00;
      buf_wr_ready = !sink_hold && ($urandom_range(0, 99) >= stall_pct);
      #1;
      if (wedge && (nrz_out_vld || wr_gate)) wedge_viol++;
      if (!busy && buf_rd_ready) idle_fetch++;
      if (buf_rd_valid && buf_rd_ready) void'(src_q.pop_front());
      if (chk_req && chk_src_q.size() > 0) void'(chk_src_q.pop_front());
      if (nrz_out_vld) begin
         wr_bytes++;
         if (exp_wr_q.size() == 0) check(0, "R2", "unexpected write byte", nrz_out, -1);
         else check(nrz_out == exp_wr_q.pop_front(), "R2", "write byte", nrz_out, -2);
      end
      if (rd_active && byte_en && !wedge && rd_stream_q.size() > 0) void'(rd_stream_q.pop_front());
      if (buf_wr_valid && buf_wr_ready) begin
         buf_bytes++;
         if (cmp_buf) begin
            if (exp_buf_q.size() == 0) check(0, "R4", "unexpected buffer byte", buf_wr_data, -1);
            else begin
               automatic logic [7:0] e = exp_buf_q.pop_front();
               check(buf_wr_data == e, "R4", "buffer byte", buf_wr_data, e);
            end
         end
      end
      if (chk_out_valid) begin
         if (exp_chk_q.size() == 0) check(0, "R4", "unexpected check byte", chk_out_data, -1);
         else begin
            automatic logic [7:0] e = exp_chk_q.pop_front();
            check(chk_out_data == e, "R4", "check byte", chk_out_data, e);
         end
      end
      if (done) done_cnt++;
   end

   // driver: queue a write job (user bytes then check bytes per sector)
   task automatic push_write(int ulen, int clen, int secs, int extra);
      for (int s = 0; s < secs; s++) begin
         for (int i = 0; i < ulen; i++) begin
            automatic logic [7:0] b = 8'($urandom);
            src_q.push_back(b);
            exp_wr_q.push_back(b);
         end
         for (int k = 0; k < clen; k++) begin
            automatic logic [7:0] c = 8'($urandom);
            chk_src_q.push_back(c);
            exp_wr_q.push_back(c);
         end
      end
      for (int x = 0; x < extra; x++) src_q.push_back(8'($urandom));
   endtask

   // driver: queue a read job
   task automatic push_read(int ulen, int clen, int secs);
      for (int s = 0; s < secs; s++) begin
         for (int i = 0; i < ulen; i++) begin
            automatic logic [7:0] b = 8'($urandom);
            rd_stream_q.push_back(b);
            exp_buf_q.push_back(b);
         end
         for (int k = 0; k < clen; k++) begin
            automatic logic [7:0] c = 8'($urandom);
            rd_stream_q.push_back(c);
            exp_chk_q.push_back(c);
         end
      end
   endtask

   task automatic pulse_start(bit wr, int secs);
      @(negedge clk);
      start = 1'b1;
      start_write = wr;
      start_secs = 8'(secs);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic begin_xfer(bit wr, int secs);
      pulse_start(wr, secs);
      rd_active = !wr;
      repeat (4) @(negedge clk);
      chan_on = 1'b1;
   endtask

   task automatic wait_done(int limit, output bit got);
      automatic int d0 = done_cnt;
      got = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (done_cnt > d0) begin
            got = 1;
            break;
         end
      end
      #2;
      chan_on = 1'b0;
      rd_active = 1'b0;
   endtask

   task automatic finish_run();
      check(wedge_viol == 0, "R3", "bytes or gate during wedge", wedge_viol, 0);
      check(idle_fetch == 0, "R10", "fetch while idle", idle_fetch, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      check(0, "R8", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      bit got;
      int d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      check({busy, done, wr_gate, nrz_out_vld, chk_req, chk_out_valid, buf_wr_valid,
             err_underrun, err_overrun} == '0, "R1", "reset outputs",
            {busy, done, wr_gate, nrz_out_vld, chk_req, chk_out_valid, buf_wr_valid,
             err_underrun, err_overrun}, 0);

      // R2 R3 R9 R10: write, 3 sectors of 6+2, random wedges, stray start while busy
      cfg_user_len = 12'd6; cfg_chk_len = 6'd2;
      be_div = 2; wedge_pct = 10; stall_pct = 0;
      wr_bytes = 0; d0 = done_cnt;
      push_write(6, 2, 3, 5);
      begin_xfer(1, 3);
      repeat (6) @(negedge clk);
      start = 1'b1; start_write = 1'b0; start_secs = 8'd1;   // R9 ignored while busy
      @(negedge clk);
      start = 1'b0;
      wait_done(2000, got);
      check(got, "R8", "write done seen", got, 1);
      check(done_cnt - d0 == 1, "R8", "one done pulse", done_cnt - d0, 1);
      check(busy == 0, "R8", "busy after done", busy, 0);
      check(wr_bytes == 24, "R2", "bytes emitted", wr_bytes, 24);
      check(exp_wr_q.size() == 0, "R2", "scoreboard drained", exp_wr_q.size(), 0);
      check(src_q.size() == 5, "R10", "fetch stops at total", src_q.size(), 5);
      src_q.delete();

      // R4 R3: read, 2 sectors of 5+3, sink stalls, wedges
      cfg_user_len = 12'd5; cfg_chk_len = 6'd3;
      stall_pct = 30; buf_bytes = 0; d0 = done_cnt;
      push_read(5, 3, 2);
      begin_xfer(0, 2);
      wait_done(2000, got);
      check(got, "R8", "read done after drain", got, 1);
      check(buf_bytes == 10, "R4", "user bytes to buffer", buf_bytes, 10);
      check(exp_buf_q.size() == 0, "R4", "buffer scoreboard drained", exp_buf_q.size(), 0);
      check(exp_chk_q.size() == 0, "R4", "check scoreboard drained", exp_chk_q.size(), 0);
      check(err_overrun == 0, "R7", "no overrun at normal rate", err_overrun, 0);

      // R5: default lengths
      cfg_user_len = 12'd0; cfg_chk_len = 6'd0;
      stall_pct = 0; wedge_pct = 3; wr_bytes = 0;
      push_write(512, 4, 1, 0);
      begin_xfer(1, 1);
      wait_done(20000, got);
      check(got, "R5", "default write done", got, 1);
      check(wr_bytes == 516, "R5", "default sector bytes", wr_bytes, 516);
      check(exp_wr_q.size() == 0, "R5", "default scoreboard drained", exp_wr_q.size(), 0);

      // R9: zero sector start ignored
      pulse_start(1, 0);
      repeat (4) @(negedge clk);
      #1;
      check(busy == 0, "R9", "zero-sector start ignored", busy, 0);

      // R6: underrun
      cfg_user_len = 12'd6; cfg_chk_len = 6'd2;
      wedge_pct = 0; be_div = 1; wr_bytes = 0; d0 = done_cnt;
      for (int i = 0; i < 3; i++) begin
         automatic logic [7:0] b = 8'($urandom);
         src_q.push_back(b);
         exp_wr_q.push_back(b);
      end
      begin_xfer(1, 1);
      repeat (30) @(negedge clk);
      #1;
      check(err_underrun == 1, "R6", "underrun flag", err_underrun, 1);
      check(busy == 0, "R6", "transfer aborted", busy, 0);
      check(wr_gate == 0, "R6", "write gate dropped", wr_gate, 0);
      check(done_cnt == d0, "R6", "no done on underrun", done_cnt - d0, 0);
      check(wr_bytes == 3, "R6", "bytes before underrun", wr_bytes, 3);
      chan_on = 1'b0;
      exp_wr_q.delete();
      push_write(6, 2, 1, 0);
      begin_xfer(1, 1);
      #1;
      check(err_underrun == 0, "R6", "cleared by new start", err_underrun, 0);
      wait_done(2000, got);
      check(got && exp_wr_q.size() == 0, "R6", "clean write after underrun", exp_wr_q.size(), 0);

      // R7: overrun with a blocked sink
      cfg_user_len = 12'd20; cfg_chk_len = 6'd2;
      be_div = 1; sink_hold = 1; cmp_buf = 0; buf_bytes = 0; d0 = done_cnt;
      exp_buf_q.delete();
      push_read(20, 2, 1);
      exp_buf_q.delete();
      begin_xfer(0, 1);
      while (rd_stream_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
      check(err_overrun == 1, "R7", "overrun flag", err_overrun, 1);
      check(busy == 1, "R7", "waiting for drain", busy, 1);
      sink_hold = 0;
      wait_done(500, got);
      check(got, "R7", "done after overrun", got, 1);
      check(buf_bytes == 8, "R7", "bytes kept in FIFO", buf_bytes, 8);
      check(exp_chk_q.size() == 0, "R7", "check bytes still delivered", exp_chk_q.size(), 0);
      check(err_overrun == 1, "R7", "overrun sticky", err_overrun, 1);

      finish_run();
   end
endmodule